// File: doc/BRIEF.md
# Scatter-Gather Page Walker

This block converts a linear byte range into physical memory bursts. A caller
hands it the address of a page descriptor table, the largest legal entry
index, a linear start address, a byte count and a transfer direction, then
pulses `start`. The walker splits the linear address into an entry index (the
address divided by the page size) and an offset within that page. It reads one
descriptor per page through a small read-request port, then passes each
physical chunk on to a downstream data mover with a valid/ready handshake.

Each descriptor is an 8-byte slot in the table. The block reads only the
32-bit word at the start of the slot, which holds the physical page address.
The word at slot offset 4 is never requested. The first chunk runs from the
start offset to the end of its page. Every later chunk starts at offset zero
of the next entry and covers a whole page. Any chunk is cut short when the
remaining byte count runs out. If the walk needs an entry beyond the
programmed maximum index, it stops at that point and completes with an error.

Top module: `sg_page_walker`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `err`, `chk_valid` and `mem_rd_valid` are all low.
- R2: A walk's first descriptor read targets `tbl_base + 8*(lin_addr / PAGE_BYTES)`. Each later read targets the next 8-byte slot. Every read address is congruent to `tbl_base` modulo 8, so the second word of a slot is never read.
- R3: A chunk's physical address is the descriptor word returned for its entry plus the in-page offset. That offset is `lin_addr % PAGE_BYTES` for the first chunk and zero for all later chunks.
- R4: The first chunk's byte count is the smaller of `PAGE_BYTES - offset` and the length. Each later count is the smaller of `PAGE_BYTES` and the bytes still left. The counts add up to the length, and each is between 1 and `PAGE_BYTES`.
- R5: `chk_wr` on every chunk equals `dir_wr` as sampled at the accepted start (1 = memory write, 0 = memory read).
- R6: When the walk needs an entry whose index is greater than `max_idx`, it issues no read for that entry and ends with `err` high at `done`. Chunks for earlier entries are still delivered. A walk that never passes the bound ends with `err` low.
- R7: A zero-length start completes with a `done` pulse, no descriptor read, no chunk and `err` low.
- R8: A raised `chk_valid` or `mem_rd_valid` stays high, with its address (and count) unchanged, until the matching ready is seen.
- R9: `start` has no effect while `busy` is high. The walk in progress delivers exactly its original chunks.
- R10: `start` in the same cycle as the `done` pulse launches a new walk.
- R11: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse while `busy` is low. `err` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a walk (taken only while idle) |
| tbl_base | input | ADDR_W | Byte address of descriptor table |
| max_idx | input | MAXI_W | Largest legal entry index |
| lin_addr | input | ADDR_W | Linear start byte address |
| xfer_len | input | LEN_W | Byte count of the walk |
| dir_wr | input | 1 | 1 = chunks are writes, 0 = reads |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last walk exceeded the table bound |
| mem_rd_valid | output | 1 | Descriptor read request valid |
| mem_rd_addr | output | ADDR_W | Descriptor read byte address |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rsp_valid | input | 1 | Read data valid (after acceptance) |
| mem_rsp_data | input | ADDR_W | Little-endian descriptor word |
| chk_valid | output | 1 | Chunk request valid |
| chk_addr | output | ADDR_W | Chunk physical address |
| chk_bytes | output | log2(PAGE_BYTES)+1 | Chunk byte count |
| chk_wr | output | 1 | Chunk direction |
| chk_ready | input | 1 | Downstream accepts chunk |

## Verification
Two events can land in the same cycle: the completion pulse of one walk and the start of the next. The bench launches every walk after the first at the very negedge where it sees `done`, so each `start` meets the pulse. It then checks that the new walk's descriptor reads and chunks match the arithmetic model from its first cycle. The opposite case is also covered: a `start` carrying unrelated parameters is raised in the middle of a walk while a descriptor read or chunk handshake may be pending. That walk must still yield exactly its own chunks. Ready patterns on both ports stall on changing cycles, so these overlaps hit the FSM in different states.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  typedef enum logic [2:0] {
    W_IDLE   = 3'd0,
    W_CHECK  = 3'd1,
    W_FETCH  = 3'd2,
    W_EMIT   = 3'd3,
    W_FINISH = 3'd4
  } walk_state_e;

  localparam int unsigned SLOT_SHIFT = 3;  // 8-byte descriptor slots

endpackage

// File: rtl/sg_span_calc.sv
module sg_span_calc #(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned CNT_W      = PAGE_SHIFT + 1
) (
  input  logic [PAGE_SHIFT-1:0] off,
  input  logic [LEN_W-1:0]      rem,
  output logic [CNT_W-1:0]      span
);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(1) << PAGE_SHIFT;

  logic [CNT_W-1:0] room;

  always_comb begin
    room = PAGE_CNT - CNT_W'(off);
    if (rem < LEN_W'(room)) span = CNT_W'(rem);
    else                    span = room;
  end
endmodule

// File: rtl/sg_desc_port.sv
module sg_desc_port #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_data,
  output logic              got,
  output logic [ADDR_W-1:0] page
);
  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      waiting  <= 1'b0;
      got      <= 1'b0;
      page     <= '0;
    end else begin
      got <= 1'b0;
      if (issue) begin
        rd_valid <= 1'b1;
        rd_addr  <= issue_addr;
      end else if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        waiting  <= 1'b1;
      end
      if (waiting && rsp_valid) begin
        waiting <= 1'b0;
        got     <= 1'b1;
        page    <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/sg_chunk_reg.sv
module sg_chunk_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_bytes,
  input  logic              ld_wr,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  bytes,
  output logic              wr,
  input  logic              ready,
  output logic              taken
);
  assign taken = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      bytes <= '0;
      wr    <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      bytes <= ld_bytes;
      wr    <= ld_wr;
    end else if (taken) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sg_page_walker.sv
module sg_page_walker
  import sg_walk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned MAXI_W     = 20,
  parameter int unsigned PAGE_BYTES = 4096,
  localparam int unsigned PAGE_SHIFT = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W      = PAGE_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [MAXI_W-1:0] max_idx,
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              dir_wr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              chk_valid,
  output logic [ADDR_W-1:0] chk_addr,
  output logic [CNT_W-1:0]  chk_bytes,
  output logic              chk_wr,
  input  logic              chk_ready
);
  localparam int unsigned IDX_W = ADDR_W - PAGE_SHIFT;

  walk_state_e           state;
  logic [IDX_W-1:0]      idx_q, max_q;
  logic [PAGE_SHIFT-1:0] off_q;
  logic [LEN_W-1:0]      rem_q;
  logic [ADDR_W-1:0]     base_q;
  logic                  wr_q, err_q, done_q;

  logic                  over_bound, issue, load, got, taken;
  logic [ADDR_W-1:0]     page, slot_addr;
  logic [CNT_W-1:0]      span;

  assign over_bound = idx_q > max_q;
  assign issue      = (state == W_CHECK) && !over_bound;
  assign load       = (state == W_FETCH) && got;
  assign slot_addr  = base_q + ADDR_W'({idx_q, {SLOT_SHIFT{1'b0}}});

  sg_span_calc #(
    .PAGE_SHIFT(PAGE_SHIFT), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_span (
    .off(off_q), .rem(rem_q), .span(span)
  );

  sg_desc_port #(.ADDR_W(ADDR_W)) u_desc (
    .clk(clk), .rst(rst),
    .issue(issue), .issue_addr(slot_addr),
    .rd_valid(mem_rd_valid), .rd_addr(mem_rd_addr), .rd_ready(mem_rd_ready),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .got(got), .page(page)
  );

  sg_chunk_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chunk (
    .clk(clk), .rst(rst),
    .load(load), .ld_addr(page + ADDR_W'(off_q)), .ld_bytes(span), .ld_wr(wr_q),
    .valid(chk_valid), .addr(chk_addr), .bytes(chk_bytes), .wr(chk_wr),
    .ready(chk_ready), .taken(taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= W_IDLE;
      idx_q  <= '0;
      max_q  <= '0;
      off_q  <= '0;
      rem_q  <= '0;
      base_q <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        W_IDLE: if (start) begin
          base_q <= tbl_base;
          max_q  <= IDX_W'(max_idx);
          idx_q  <= lin_addr[ADDR_W-1:PAGE_SHIFT];
          off_q  <= lin_addr[PAGE_SHIFT-1:0];
          rem_q  <= xfer_len;
          wr_q   <= dir_wr;
          err_q  <= 1'b0;
          state  <= (xfer_len == '0) ? W_FINISH : W_CHECK;
        end
        W_CHECK: begin
          if (over_bound) begin
            err_q <= 1'b1;
            state <= W_FINISH;
          end else begin
            state <= W_FETCH;
          end
        end
        W_FETCH: if (got) state <= W_EMIT;
        W_EMIT: if (taken) begin
          rem_q <= rem_q - LEN_W'(span);
          if (rem_q == LEN_W'(span)) begin
            state <= W_FINISH;
          end else begin
            idx_q <= idx_q + 1'b1;
            off_q <= '0;
            state <= W_CHECK;
          end
        end
        W_FINISH: begin
          done_q <= 1'b1;
          state  <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assign busy = (state != W_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned CNT_W      = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] tbl_base,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ready,
  input logic              chk_valid,
  input logic [ADDR_W-1:0] chk_addr,
  input logic [CNT_W-1:0]  chk_bytes,
  input logic              chk_ready
);
  logic [2:0] base_lo;

  always_ff @(posedge clk) begin
    if (rst) base_lo <= '0;
    else if (start && !busy) base_lo <= tbl_base[2:0];
  end

  assert_chunk_hold_R8: assert property (@(posedge clk) disable iff (rst)
    chk_valid && !chk_ready |=> chk_valid && $stable(chk_addr) && $stable(chk_bytes));

  assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_chunk_size_R4: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> (chk_bytes != '0) && (chk_bytes <= CNT_W'(PAGE_BYTES)));

  assert_slot_align_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> mem_rd_addr[2:0] == base_lo);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !chk_valid && !mem_rd_valid);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy ##1 !done);

  assert_err_in_walk_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> busy);
endmodule

bind sg_page_walker sg_walker_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .tbl_base(tbl_base),
  .busy(busy), .done(done), .err(err),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
  .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_bytes(chk_bytes), .chk_ready(chk_ready)
);

// File: tb/sim_sg_page_walker.sv
`timescale 1ns/1ps
module sim_sg_page_walker;
  localparam int P      = 16;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int MAXI_W = 6;
  localparam int CNT_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ADDR_W-1:0] tbl_base = '0;
  logic [MAXI_W-1:0] max_idx = '0;
  logic [ADDR_W-1:0] lin_addr = '0;
  logic [LEN_W-1:0]  xfer_len = '0;
  logic dir_wr = 1'b0;
  logic busy, done, err;
  logic mem_rd_valid;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic mem_rd_ready = 1'b0;
  logic mem_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] mem_rsp_data = '0;
  logic chk_valid;
  logic [ADDR_W-1:0] chk_addr;
  logic [CNT_W-1:0] chk_bytes;
  logic chk_wr;
  logic chk_ready = 1'b0;

  always #4 clk = ~clk;

  sg_page_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAXI_W(MAXI_W), .PAGE_BYTES(P)) u0 (
    .clk(clk), .rst(rst), .start(start), .tbl_base(tbl_base), .max_idx(max_idx),
    .lin_addr(lin_addr), .xfer_len(xfer_len), .dir_wr(dir_wr),
    .busy(busy), .done(done), .err(err),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_bytes(chk_bytes), .chk_wr(chk_wr),
    .chk_ready(chk_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int gcyc    = 0;
  always @(posedge clk) gcyc <= gcyc + 1;

  logic [31:0] ex_fa [0:63];
  logic [31:0] ex_ca [0:63];
  int          ex_cb [0:63];

  function automatic logic [31:0] page_of(input int i);
    return 32'h0004_0000 + 32'(i) * 32'h310;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Runs one walk; called at a negedge, returns at the negedge where done is seen.
  task automatic run_job(input logic [31:0] base, input int mx, input int a, input int n,
                         input bit wr, input bit poke, input bit chained);
    int idx, off, rem, cb, ne, nf, nc, cyc;
    bit ee, pend, stall_prev;
    logic [31:0] prev_addr;
    idx = a / P; off = a % P; rem = n; ne = 0; ee = 1'b0;
    while (rem > 0) begin
      if (idx > mx) begin ee = 1'b1; break; end
      ex_fa[ne] = base + 32'(8 * idx);
      cb = (P - off < rem) ? P - off : rem;
      ex_ca[ne] = page_of(idx) + 32'(off);
      ex_cb[ne] = cb;
      ne++; rem -= cb; idx++; off = 0;
    end
    tbl_base = base; max_idx = MAXI_W'(mx); lin_addr = 32'(a);
    xfer_len = LEN_W'(n); dir_wr = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nf = 0; nc = 0; cyc = 0; pend = 1'b0; stall_prev = 1'b0; prev_addr = '0;
    check(busy == 1'b1, chained ? "R10 launch in done cycle" : "R11 busy after start",
          longint'(busy), 1);
    forever begin
      if (poke && cyc == 0) begin
        start = 1'b1; tbl_base = 32'h55; lin_addr = 32'h0; xfer_len = LEN_W'(3); dir_wr = ~wr;
      end else begin
        start = 1'b0;
      end
      if (pend) begin
        mem_rsp_valid = 1'b1;
        if (((mem_rd_addr - base) & 32'h7) != 0) mem_rsp_data = 32'hBAD0_0000;
        else mem_rsp_data = page_of(int'((mem_rd_addr - base) >> 3));
        pend = 1'b0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (stall_prev)
        check(chk_valid && chk_addr == prev_addr, "R8 chunk held under stall", longint'(chk_addr), longint'(prev_addr));
      if (done) break;
      mem_rd_ready = ((gcyc % 3) != 1);
      chk_ready    = ((gcyc % 4) != 2) && ((gcyc % 7) != 3);
      if (mem_rd_valid && mem_rd_ready) begin
        if (nf < ne) check(mem_rd_addr == ex_fa[nf], "R2 descriptor address", longint'(mem_rd_addr), longint'(ex_fa[nf]));
        else check(1'b0, "R6 extra descriptor read", longint'(mem_rd_addr), 0);
        nf++; pend = 1'b1;
      end
      if (chk_valid && chk_ready) begin
        if (nc < ne) begin
          check(chk_addr == ex_ca[nc], "R3 chunk address", longint'(chk_addr), longint'(ex_ca[nc]));
          check(int'(chk_bytes) == ex_cb[nc], "R4 chunk size", longint'(chk_bytes), longint'(ex_cb[nc]));
          check(chk_wr == wr, "R5 chunk direction", longint'(chk_wr), longint'(wr));
        end else begin
          check(1'b0, poke ? "R9 stray chunk" : "R4 extra chunk", longint'(chk_addr), 0);
        end
        nc++;
      end
      stall_prev = chk_valid && !chk_ready;
      prev_addr  = chk_addr;
      @(negedge clk);
      cyc++;
      if (cyc > 600) begin
        check(1'b0, "R11 walk never finished", cyc, 600);
        return;
      end
    end
    mem_rsp_valid = 1'b0;
    check(busy == 1'b0, "R11 idle at done", longint'(busy), 0);
    check(nf == ne, n == 0 ? "R7 reads on empty walk" : "R2 descriptor read count", nf, ne);
    check(nc == ne, poke ? "R9 chunk count with stray start" : "R4 chunk count", nc, ne);
    check(err == ee, n == 0 ? "R7 error flag" : "R6 error flag", longint'(err), longint'(ee));
  endtask

  int lens [0:6] = '{0, 1, 7, 15, 16, 17, 40};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && !err && !chk_valid && !mem_rd_valid, "R1 reset state",
          {busy, done, err, chk_valid, mem_rd_valid}, 0);
    for (int o = 0; o < P; o++) begin
      for (int li = 0; li < 7; li++) begin
        run_job(32'h0000_8000 + 32'(o * 8), 63, 3 * P + o, lens[li], li[0], (li % 5) == 3,
                !(o == 0 && li == 0));
      end
    end
    run_job(32'h0000_2000, 2, 2 * P + 5, 40, 1'b1, 1'b0, 1'b1);
    run_job(32'h0000_2000, 2, 5 * P,      4, 1'b0, 1'b0, 1'b1);
    run_job(32'h0000_2004, 0, 0,         16, 1'b1, 1'b0, 1'b1);
    run_job(32'h0000_2004, 0, 0,         17, 1'b0, 1'b1, 1'b1);
    run_job(32'h0000_3000, 63, 63 * P + 8, 8, 1'b1, 1'b0, 1'b1);
    run_job(32'h0000_3000, 63, 63 * P + 8, 9, 1'b0, 1'b0, 1'b1);
    run_job(32'h0000_3000, 1, 60 * P,     0, 1'b1, 1'b0, 1'b1);
    run_job(32'h0000_3000, 1, 60 * P,    40, 1'b0, 1'b1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", gcyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule